// File: doc/BRIEF.md
# Serial Command Register Bridge

This block is a serial-peripheral slave that turns byte frames from a host microcontroller into single-cycle accesses on an internal register bus. A frame opens when the active-low select falls. Its first byte is a command that picks the direction, whether the register offset steps per byte, one of four register regions and a starting offset. After that command, each byte of a write frame becomes one write strobe. A read frame spends one pad byte while the first register is fetched, and then returns one register per byte.

Region 0 (control) sits inside the block. It holds an identity byte, a version byte and a run register that releases the attached processor from reset. Regions 1 (processor interface), 2 (memory port) and 3 (trace scope) are outside the block and are reached through the strobe bus. The serial inputs are oversampled by the system clock, so the serial clock must run well below the system clock. Each serial half-period must last at least six system clocks.

Top module: `spi_reg_bridge`

## Requirements
- R1: The command byte uses bit 7 as write (1) or read (0) and bit 6 as auto-step. Bits 5:4 give the region (0 control, 1 processor, 2 memory, 3 scope) and bits 3:0 give the starting offset. External strobes show that region on `bus_region` and the current offset on `bus_offset`.
- R2: In a write frame, every complete data byte produces exactly one single-cycle `bus_wr` pulse, with the byte value on `bus_wdata`.
- R3: With auto-step set, the offset rises by one after each register access and wraps from 15 to 0 inside the same region. With auto-step clear, every access in the frame uses the starting offset.
- R4: Serial mode 0, most significant bit first. In a read frame the byte after the command reads back as 0x00, and the register values start on the byte after it.
- R5: Read data is taken from `bus_rdata` in the cycle `bus_rd` is high. A read frame that returns N data bytes issues N+2 read strobes, because the block fetches ahead.
- R6: Raising select ends the frame and discards any partial byte. The next frame starts with a fresh command byte.
- R7: The control region returns 0x42 at offset 0 and 0x01 at offset 1. Control-region accesses never raise `bus_wr` or `bus_rd`.
- R8: `cpu_reset` is high after reset. Writing a byte to control offset 2 stores it, and that byte reads back. Bit 0 of the stored byte equal to 1 drives `cpu_reset` low, and equal to 0 drives it high again.
- R9: `spi_miso` is low while select is high. After reset, `bus_wr` and `bus_rd` are low.
- R10: `bus_wr` and `bus_rd` are never high in the same cycle, and no strobe occurs while the synchronized select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_region | output | 2 | Region of the current access |
| bus_offset | output | 4 | Register offset of the current access |
| bus_wdata | output | 8 | Write data, valid with bus_wr |
| bus_wr | output | 1 | External write strobe, one cycle |
| bus_rd | output | 1 | External read strobe, one cycle |
| bus_rdata | input | 8 | External read data, sampled with bus_rd |
| cpu_reset | output | 1 | Reset to the attached processor, active high |

## Verification
Write frames are run with auto-step on in one region and off in another. One starting offset of 14 shows whether the offset wraps inside the region or runs into the region bits. Read frames compare each returned byte against a value that depends on both region and offset, so a misplaced pad byte, an off-by-one fetch or a wrong region shows up as a data mismatch. The strobe scoreboard also catches a missing or extra prefetch. Control-region frames check the identity bytes and the run register, and confirm that no external strobes occur. A frame cut off mid-byte shows whether partial data leaks into a strobe.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 4;
    localparam int RGN_W  = 2;

    localparam logic [RGN_W-1:0] RGN_CTRL = '0;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_PAD,
        PH_DATA
    } phase_e;

    // command byte layout, most significant field first
    typedef struct packed {
        logic             wr;
        logic             inc;
        logic [RGN_W-1:0] region;
        logic [OFF_W-1:0] off;
    } cmd_t;
endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stg_d[g] = din;
            end else begin : g_next
                assign stg_d[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_bridge_shifter.sv
module spi_bridge_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic [DW-1:0] tx_next,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          miso
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic          sclk_prev;
        logic [CW-1:0] bitcnt;
        logic [DW-1:0] rx;
        logic [DW-1:0] tx;
        logic          load_pend;
    } shf_t;

    shf_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        rise = sclk_s & ~s_q.sclk_prev;
        fall = ~sclk_s & s_q.sclk_prev;
        s_d = s_q;
        s_d.sclk_prev = sclk_s;
        if (cs_n_s) begin
            s_d.bitcnt    = '0;
            s_d.tx        = '0;
            s_d.load_pend = 1'b0;
        end else begin
            if (rise) begin
                s_d.rx = {s_q.rx[DW-2:0], mosi_s};
                if (s_q.bitcnt == LAST) begin
                    s_d.bitcnt    = '0;
                    s_d.load_pend = 1'b1;
                end else begin
                    s_d.bitcnt = s_q.bitcnt + 1'b1;
                end
            end
            if (fall) begin
                if (s_q.load_pend) begin
                    s_d.tx        = tx_next;
                    s_d.load_pend = 1'b0;
                end else begin
                    s_d.tx = {s_q.tx[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_done = ~cs_n_s & rise & (s_q.bitcnt == LAST);
    assign rx_byte   = {s_q.rx[DW-2:0], mosi_s};
    assign miso      = ~cs_n_s & s_q.tx[DW-1];
endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl #(
    parameter int         DW      = 8,
    parameter int         OW      = 4,
    parameter logic [7:0] ID_VAL  = 8'h42,
    parameter logic [7:0] VER_VAL = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          cpu_reset
);
    localparam logic [OW-1:0] OFF_ID  = OW'(0);
    localparam logic [OW-1:0] OFF_VER = OW'(1);
    localparam logic [OW-1:0] OFF_RUN = OW'(2);

    logic [DW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (wr && off == OFF_RUN) run_d = wdata;
        case (off)
            OFF_ID:  rdata = DW'(ID_VAL);
            OFF_VER: rdata = DW'(VER_VAL);
            OFF_RUN: rdata = run_q;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign cpu_reset = ~run_q[0];
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_bridge_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_VAL      = 8'h42,
    parameter logic [7:0] VER_VAL     = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic [RGN_W-1:0] bus_region,
    output logic [OFF_W-1:0] bus_offset,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic             cpu_reset
);
    logic              cs_sync, sclk_sync, mosi_sync;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte, ctl_rdata, rd_mux;
    logic              strobe_wr, strobe_rd, ctl_wr;
    logic [OFF_W-1:0]  cur_off;

    spi_bridge_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout  ({cs_sync, sclk_sync, mosi_sync})
    );

    typedef struct packed {
        phase_e            phase;
        cmd_t              cmd;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] pending;
        logic [BYTE_W-1:0] txn;
        logic              fetch;
    } frm_t;

    frm_t f_d, f_q;

    spi_bridge_shifter #(.DW(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_sync),
        .cs_n_s    (cs_sync),
        .mosi_s    (mosi_sync),
        .tx_next   (f_q.txn),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    assign rd_mux = (f_q.cmd.region == RGN_CTRL) ? ctl_rdata : bus_rdata;

    always_comb begin
        f_d       = f_q;
        strobe_wr = 1'b0;
        strobe_rd = 1'b0;
        if (cs_sync) begin
            f_d.phase = PH_CMD;
            f_d.fetch = 1'b0;
        end else begin
            if (f_q.fetch) begin
                strobe_rd   = 1'b1;
                f_d.pending = rd_mux;
                f_d.fetch   = 1'b0;
                if (f_q.cmd.inc) f_d.off = f_q.off + 1'b1;
            end
            if (byte_done) begin
                unique case (f_q.phase)
                    PH_CMD: begin
                        f_d.cmd   = cmd_t'(rx_byte);
                        f_d.off   = rx_byte[OFF_W-1:0];
                        f_d.txn   = '0;
                        f_d.phase = rx_byte[BYTE_W-1] ? PH_DATA : PH_PAD;
                        f_d.fetch = ~rx_byte[BYTE_W-1];
                    end
                    PH_PAD: begin
                        f_d.txn   = f_q.pending;
                        f_d.fetch = 1'b1;
                        f_d.phase = PH_DATA;
                    end
                    default: begin
                        if (f_q.cmd.wr) begin
                            strobe_wr = 1'b1;
                            if (f_q.cmd.inc) f_d.off = f_q.off + 1'b1;
                        end else begin
                            f_d.txn   = f_q.pending;
                            f_d.fetch = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{phase: PH_CMD, default: '0};
        else        f_q <= f_d;
    end

    assign cur_off    = f_q.off;
    assign ctl_wr     = strobe_wr & (f_q.cmd.region == RGN_CTRL);
    assign bus_wr     = strobe_wr & (f_q.cmd.region != RGN_CTRL);
    assign bus_rd     = strobe_rd & (f_q.cmd.region != RGN_CTRL);
    assign bus_region = f_q.cmd.region;
    assign bus_offset = f_q.off;
    assign bus_wdata  = rx_byte;

    spi_bridge_ctrl #(
        .DW      (BYTE_W),
        .OW      (OFF_W),
        .ID_VAL  (ID_VAL),
        .VER_VAL (VER_VAL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .off       (cur_off),
        .wdata     (rx_byte),
        .rdata     (ctl_rdata),
        .cpu_reset (cpu_reset)
    );
endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       cpu_reset,
    input logic       ctl_wr,
    input logic [3:0] cur_off,
    input logic       cs_sync
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd}));

    // R10
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> !cs_sync);

    // R2
    wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    // R8
    run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_reset) |-> $past(ctl_wr && cur_off == 4'd2));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_reset) |-> $past(ctl_wr && cur_off == 4'd2));
endmodule

bind spi_reg_bridge spi_reg_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cpu_reset (cpu_reset),
    .ctl_wr    (ctl_wr),
    .cur_off   (cur_off),
    .cs_sync   (cs_sync)
);

// File: tb/spi_reg_bridge_test.sv
module spi_reg_bridge_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [1:0] bus_region;
    logic [3:0] bus_offset;
    logic [7:0] bus_wdata;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_rdata;
    logic       cpu_reset;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ctl_run = 8'h00;

    typedef struct {
        bit       wr;
        bit [1:0] rg;
        bit [3:0] off;
        bit [7:0] d;
    } item_t;
    item_t expq[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] ext_val(input logic [1:0] rg, input logic [3:0] off);
        return {rg, 2'b01, off} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] ctl_val(input logic [3:0] off);
        case (off)
            4'd0:    return 8'h42;
            4'd1:    return 8'h01;
            4'd2:    return ctl_run;
            default: return 8'h00;
        endcase
    endfunction

    assign bus_rdata = ext_val(bus_region, bus_offset);

    spi_reg_bridge uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .bus_region (bus_region),
        .bus_offset (bus_offset),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .cpu_reset  (cpu_reset)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && (bus_wr || bus_rd)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6/R7 unexpected strobe", {bus_wr, bus_rd, bus_offset, bus_region}, 8'h00);
            end else begin
                item_t it;
                it = expq.pop_front();
                check(bus_wr == it.wr, "R1 strobe kind", {7'd0, bus_wr}, {7'd0, it.wr});
                check(bus_region == it.rg, "R1 region", {6'd0, bus_region}, {6'd0, it.rg});
                check(bus_offset == it.off, "R3 offset", {4'd0, bus_offset}, {4'd0, it.off});
                if (it.wr) check(bus_wdata == it.d, "R2 write data", bus_wdata, it.d);
            end
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nb; i++) begin
            spi_mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx[7-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_begin();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic wr_frame(input logic [1:0] rg, input logic [3:0] off, input bit inc,
                            input int n, input logic [7:0] seed);
        logic [7:0] rx;
        frame_begin();
        spi_bits({1'b1, inc, rg, off}, 8, rx);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            logic [3:0] o;
            d = seed + 8'(k * 17);
            o = off + (inc ? 4'(k) : 4'd0);
            if (rg != 2'd0) expq.push_back('{1'b1, rg, o, d});
            else if (o == 4'd2) ctl_run = d;
            spi_bits(d, 8, rx);
        end
        frame_end();
    endtask

    task automatic rd_frame(input logic [1:0] rg, input logic [3:0] off, input bit inc,
                            input int n, input string req);
        logic [7:0] rx, e;
        logic [3:0] o;
        for (int k = 0; k < n + 2; k++) begin
            o = off + (inc ? 4'(k) : 4'd0);
            if (rg != 2'd0) expq.push_back('{1'b0, rg, o, 8'h00});
        end
        frame_begin();
        spi_bits({1'b0, inc, rg, off}, 8, rx);
        spi_bits(8'hFF, 8, rx);
        check(rx == 8'h00, "R4 pad byte", rx, 8'h00);
        for (int k = 0; k < n; k++) begin
            o = off + (inc ? 4'(k) : 4'd0);
            e = (rg == 2'd0) ? ctl_val(o) : ext_val(rg, o);
            spi_bits(8'hFF, 8, rx);
            check(rx == e, req, rx, e);
        end
        frame_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 8'h00, 8'h01);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(cpu_reset == 1'b1, "R8 reset cpu_reset", {7'd0, cpu_reset}, 8'h01);
        check(spi_miso == 1'b0, "R9 idle miso", {7'd0, spi_miso}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!bus_wr && !bus_rd, "R9 strobes idle", {6'd0, bus_wr, bus_rd}, 8'h00);
        check(spi_miso == 1'b0, "R9 idle miso after reset", {7'd0, spi_miso}, 8'h00);

        // R7 identity read, no external strobes
        rd_frame(2'd0, 4'd0, 1'b1, 3, "R7 control identity");
        // R8 release processor
        wr_frame(2'd0, 4'd2, 1'b0, 1, 8'h01);
        check(cpu_reset == 1'b0, "R8 released", {7'd0, cpu_reset}, 8'h00);
        rd_frame(2'd0, 4'd2, 1'b0, 2, "R8 run readback");

        // R2 R3 writes
        wr_frame(2'd1, 4'd3, 1'b1, 4, 8'hA1);
        wr_frame(2'd2, 4'd14, 1'b1, 4, 8'h10);   // R3 wrap 14,15,0,1
        wr_frame(2'd3, 4'd5, 1'b0, 3, 8'h77);    // R3 fixed offset

        // R4 R5 reads
        rd_frame(2'd1, 4'd2, 1'b1, 4, "R5 read auto-step");
        rd_frame(2'd3, 4'd15, 1'b1, 2, "R3 read wrap");
        rd_frame(2'd2, 4'd7, 1'b0, 3, "R5 read fixed");

        // R6 partial byte discarded
        frame_begin();
        spi_bits(8'hD3, 8, rx);
        spi_bits(8'hC0, 4, rx);
        frame_end();
        check(expq.size() == 0, "R6 no strobe from partial", 8'(expq.size()), 8'h00);
        wr_frame(2'd1, 4'd9, 1'b0, 1, 8'h5E);    // R6 fresh command works

        // R8 re-assert reset
        wr_frame(2'd0, 4'd2, 1'b0, 1, 8'h00);
        check(cpu_reset == 1'b1, "R8 reasserted", {7'd0, cpu_reset}, 8'h01);
        check(spi_miso == 1'b0, "R9 miso after frames", {7'd0, spi_miso}, 8'h00);

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R5 all strobes seen", 8'(expq.size()), 8'h00);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule